// File: doc/BRIEF.md
# Replacement Way Selector for a Set-Associative Cache

This block names the way of one cache set that a fill should overwrite when a lookup misses. It keeps only replacement state and sees no tags or data. The cache controller presents a set index together with the valid bits of that set's ways. It also raises a hit strobe carrying the matching way, or a miss strobe when the line will be filled. The block answers on `victim_way` combinationally from the current state, so the controller can use the answer in the same cycle that it raises the miss strobe.

The replacement policy is fixed at build time by a parameter, and there are three choices:

- **Random.** A single counter is shared by every set and steps on every clock.
- **FIFO.** Each set has its own pointer to its oldest way, and the pointer steps only when that set takes a fill.
- **LRU.** Each set keeps an exact recency order. For two ways this is one bit per set. For more ways it is a full permutation per set.

Under every policy, an empty way in the addressed set is used before the policy is consulted. With a single way there is nothing to choose.

Top module: `way_victim_sel`

## Requirements
- R1: After reset, asserted asynchronously at any time, every set in every policy names way 0 when all ways are valid. Random and FIFO counters read 0, and each LRU order has way 0 as least recent, then 1, 2, 3.
- R2: When any bit of `way_valid` is 0 (0 = empty), `victim_way` is the lowest-numbered empty way, regardless of policy state.
- R3: With WAYS = 1, `victim_way` is always 0.
- R4: Random policy with all ways valid: `victim_way` equals a single counter. The counter is 0 at reset and rises by one on every clock edge, wrapping from WAYS-1 to 0. It does not depend on set index, hits or misses.
- R5: FIFO policy with all ways valid: each set has its own pointer. The pointer rises by one, wrapping from WAYS-1 to 0, on each clock edge where `miss_vld` is high for that set, and other sets keep their pointers.
- R6: FIFO policy: hits leave every pointer unchanged.
- R7: LRU policy: a hit on way w makes w the most recently used way of that set from the next cycle on.
- R8: LRU policy: a miss makes the way being filled (the `victim_way` shown in that cycle) the most recently used way of its set.
- R9: LRU policy with 4 ways: the victim is the way of the set untouched for longest, under an exact order across all 24 permutations.
- R10: LRU policy with 2 ways: a single bit per set holds the victim, which is the way not touched most recently.
- R11: When `hit_vld` and `miss_vld` are high in the same cycle, the miss is applied and the hit is ignored.
- R12: `victim_way` follows `set_idx` and `way_valid` in the same cycle. An update from a strobe takes effect from the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | clog2(SETS) | Set addressed this cycle |
| hit_vld | input | 1 | Lookup hit in `set_idx` |
| hit_way | input | clog2(WAYS) | Way that hit |
| miss_vld | input | 1 | Lookup missed; `victim_way` is filled this cycle |
| way_valid | input | WAYS | Valid bit of each way of the addressed set |
| victim_way | output | clog2(WAYS) | Way chosen for replacement |

## Verification
The choice of way is combinational. The bench therefore drives inputs at the falling edge and reads `victim_way` one nanosecond later, inside the same low phase, before any state can move. A hit or miss strobe changes state only at the next rising edge, so its effect is first checked after the following falling edge. The random counter also steps at every rising edge. The bench counts those edges since reset and compares against that count at each check. One stimulus sequence drives LRU, FIFO, random, two-way and single-way instances side by side, with the expected victim of each worked out per row.

// File: rtl/way_sel_pkg.sv
`timescale 1ns/1ps
package way_sel_pkg;

  typedef enum logic [1:0] {
    POL_RANDOM = 2'd0,
    POL_FIFO   = 2'd1,
    POL_LRU    = 2'd2
  } repl_policy_e;

  // index width with a floor of one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wsel_first_zero.sv
`timescale 1ns/1ps
module wsel_first_zero import way_sel_pkg::*; #(
  parameter  int unsigned N = 4,
  localparam int unsigned W = idx_w(N)
) (
  input  logic [N-1:0] bits,
  output logic         found,
  output logic [W-1:0] idx
);

  // scan downward so the lowest clear bit is the last one written
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!bits[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end

endmodule

// File: rtl/wsel_rand_ctr.sv
`timescale 1ns/1ps
module wsel_rand_ctr import way_sel_pkg::*; #(
  parameter  int unsigned WAYS = 4,
  localparam int unsigned WW   = idx_w(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [WW-1:0] ptr
);

  logic [WW-1:0] ptr_q;
  logic [WW-1:0] ptr_d;

  always_comb begin
    ptr_d = (ptr_q == WW'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/wsel_fifo_ctrs.sv
`timescale 1ns/1ps
module wsel_fifo_ctrs import way_sel_pkg::*; #(
  parameter  int unsigned WAYS = 4,
  parameter  int unsigned SETS = 16,
  localparam int unsigned WW   = idx_w(WAYS),
  localparam int unsigned SW   = idx_w(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rd_set,
  output logic [WW-1:0] oldest,
  input  logic          adv,
  input  logic [SW-1:0] adv_set
);

  logic [WW-1:0] ctr_q [SETS];
  logic [WW-1:0] ctr_d [SETS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      ctr_d[s] = ctr_q[s];
      if (adv && (adv_set == SW'(s))) begin
        ctr_d[s] = (ctr_q[s] == WW'(WAYS - 1)) ? '0 : ctr_q[s] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ctr_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) ctr_q[s] <= ctr_d[s];
    end
  end

  assign oldest = ctr_q[rd_set];

endmodule

// File: rtl/wsel_lru_order.sv
`timescale 1ns/1ps
module wsel_lru_order import way_sel_pkg::*; #(
  parameter  int unsigned WAYS = 4,
  parameter  int unsigned SETS = 16,
  localparam int unsigned WW   = idx_w(WAYS),
  localparam int unsigned SW   = idx_w(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rd_set,
  output logic [WW-1:0] lru_way,
  input  logic          touch,
  input  logic [SW-1:0] touch_set,
  input  logic [WW-1:0] touch_way
);

  if (WAYS == 2) begin : g_bit
    // one bit per set holding the least recent way
    logic [SETS-1:0] lru_q;
    logic [SETS-1:0] lru_d;

    always_comb begin
      lru_d = lru_q;
      if (touch) lru_d[touch_set] = ~touch_way[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lru_q <= '0;
      else        lru_q <= lru_d;
    end

    assign lru_way = lru_q[rd_set];

  end else begin : g_list
    // slot 0 is least recent, slot WAYS-1 most recent
    typedef logic [WAYS-1:0][WW-1:0] order_t;

    order_t ord_q [SETS];
    order_t ord_d [SETS];

    function automatic order_t promote(input order_t o, input logic [WW-1:0] w);
      order_t r;
      logic   seen;
      seen = 1'b0;
      for (int p = 0; p < WAYS - 1; p++) begin
        if (o[p] == w) seen = 1'b1;
        r[p] = seen ? o[p+1] : o[p];
      end
      r[WAYS-1] = w;
      return r;
    endfunction

    always_comb begin
      for (int s = 0; s < SETS; s++) begin
        ord_d[s] = (touch && (touch_set == SW'(s))) ? promote(ord_q[s], touch_way)
                                                    : ord_q[s];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++)
          for (int p = 0; p < WAYS; p++)
            ord_q[s][p] <= WW'(p);
      end else begin
        for (int s = 0; s < SETS; s++) ord_q[s] <= ord_d[s];
      end
    end

    assign lru_way = ord_q[rd_set][0];
  end

endmodule

// File: rtl/way_victim_sel.sv
`timescale 1ns/1ps
module way_victim_sel import way_sel_pkg::*; #(
  parameter  int unsigned  WAYS   = 4,
  parameter  int unsigned  SETS   = 16,
  parameter  repl_policy_e POLICY = POL_LRU,
  localparam int unsigned  WW     = idx_w(WAYS),
  localparam int unsigned  SW     = idx_w(SETS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW-1:0]   set_idx,
  input  logic            hit_vld,
  input  logic [WW-1:0]   hit_way,
  input  logic            miss_vld,
  input  logic [WAYS-1:0] way_valid,
  output logic [WW-1:0]   victim_way
);

  if (WAYS == 1) begin : g_dm
    assign victim_way = '0;

  end else begin : g_assoc
    logic          free_any;
    logic [WW-1:0] free_way;
    logic [WW-1:0] pol_way;

    wsel_first_zero #(.N(WAYS)) u_free (
      .bits  (way_valid),
      .found (free_any),
      .idx   (free_way)
    );

    if (POLICY == POL_RANDOM) begin : g_rand
      wsel_rand_ctr #(.WAYS(WAYS)) u_rand (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr   (pol_way)
      );
    end else if (POLICY == POL_FIFO) begin : g_fifo
      wsel_fifo_ctrs #(.WAYS(WAYS), .SETS(SETS)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (set_idx),
        .oldest  (pol_way),
        .adv     (miss_vld),
        .adv_set (set_idx)
      );
    end else begin : g_lru
      logic          touch_en;
      logic [WW-1:0] touch_sel;
      // a fill outranks a hit in the same cycle
      assign touch_en  = miss_vld | hit_vld;
      assign touch_sel = miss_vld ? victim_way : hit_way;

      wsel_lru_order #(.WAYS(WAYS), .SETS(SETS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (set_idx),
        .lru_way   (pol_way),
        .touch     (touch_en),
        .touch_set (set_idx),
        .touch_way (touch_sel)
      );
    end

    assign victim_way = free_any ? free_way : pol_way;
  end

endmodule

// File: rtl/way_victim_sel_chk.sv
`timescale 1ns/1ps
module way_victim_sel_chk import way_sel_pkg::*; #(
  parameter  int unsigned  WAYS   = 4,
  parameter  int unsigned  SETS   = 16,
  parameter  repl_policy_e POLICY = POL_LRU,
  localparam int unsigned  WW     = idx_w(WAYS),
  localparam int unsigned  SW     = idx_w(SETS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SW-1:0]   set_idx,
  input logic            hit_vld,
  input logic [WW-1:0]   hit_way,
  input logic            miss_vld,
  input logic [WAYS-1:0] way_valid,
  input logic [WW-1:0]   victim_way
);

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  if (WAYS > 1) begin : g_assoc
    localparam logic [WAYS-1:0] FULL = '1;
    logic [WAYS-1:0] below;
    assign below = (WAYS'(1) << victim_way) - WAYS'(1);

    assert_pick_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (way_valid != FULL) |-> (way_valid[victim_way] == 1'b0));

    assert_lowest_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (way_valid != FULL) |-> ((way_valid & below) == below));

    if (POLICY == POL_RANDOM) begin : g_rand
      assert_rand_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(way_valid) == FULL) && (way_valid == FULL)) |->
        (victim_way == (($past(victim_way) == WW'(WAYS - 1)) ? '0 : $past(victim_way) + 1'b1)));
    end else if (POLICY == POL_FIFO) begin : g_fifo
      assert_fifo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(miss_vld) && $stable(set_idx) && $stable(way_valid) &&
         (way_valid == FULL)) |-> $stable(victim_way));

      assert_fifo_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_vld && (way_valid == FULL)) |=>
        ((set_idx != $past(set_idx)) || (way_valid != FULL) ||
         (victim_way != $past(victim_way))));
    end else begin : g_lru
      assert_lru_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vld && !miss_vld && (way_valid == FULL)) |=>
        ((set_idx != $past(set_idx)) || (way_valid != FULL) ||
         (victim_way != $past(hit_way))));

      assert_lru_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_vld |=>
        ((set_idx != $past(set_idx)) || (way_valid != FULL) ||
         (victim_way != $past(victim_way))));
    end
  end

endmodule

bind way_victim_sel way_victim_sel_chk #(
  .WAYS   (WAYS),
  .SETS   (SETS),
  .POLICY (POLICY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_idx    (set_idx),
  .hit_vld    (hit_vld),
  .hit_way    (hit_way),
  .miss_vld   (miss_vld),
  .way_valid  (way_valid),
  .victim_way (victim_way)
);

// File: tb/way_victim_sel_bench.sv
`timescale 1ns/1ps
module way_victim_sel_bench;
  import way_sel_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] set_idx;
  logic       hit_vld;
  logic [1:0] hit_way;
  logic       miss_vld;
  logic [3:0] way_valid;

  logic [1:0] v_lru4, v_fifo, v_rand;
  logic [0:0] v_lru2, v_dm;

  int total = 0;
  int fails = 0;
  int cyc;

  always #2.5 clk = ~clk;

  // rising edges seen since reset release (random counter model)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  way_victim_sel #(.WAYS(4), .SETS(16), .POLICY(POL_LRU)) u_way_victim_sel (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_vld(hit_vld), .hit_way(hit_way),
    .miss_vld(miss_vld), .way_valid(way_valid), .victim_way(v_lru4));

  way_victim_sel #(.WAYS(4), .SETS(16), .POLICY(POL_FIFO)) u_fifo (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_vld(hit_vld), .hit_way(hit_way),
    .miss_vld(miss_vld), .way_valid(way_valid), .victim_way(v_fifo));

  way_victim_sel #(.WAYS(4), .SETS(16), .POLICY(POL_RANDOM)) u_rand (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_vld(hit_vld), .hit_way(hit_way),
    .miss_vld(miss_vld), .way_valid(way_valid), .victim_way(v_rand));

  way_victim_sel #(.WAYS(2), .SETS(16), .POLICY(POL_LRU)) u_lru2 (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_vld(hit_vld), .hit_way(hit_way[0]),
    .miss_vld(miss_vld), .way_valid(way_valid[1:0]), .victim_way(v_lru2));

  way_victim_sel #(.WAYS(1), .SETS(16), .POLICY(POL_LRU)) u_dm (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_vld(hit_vld), .hit_way(hit_way[0]),
    .miss_vld(miss_vld), .way_valid(way_valid[0:0]), .victim_way(v_dm));

  typedef struct packed {
    logic [3:0] s;
    logic       h;
    logic [1:0] hw;
    logic       m;
    logic [3:0] v;
    logic [1:0] e4;
    logic [1:0] ef;
    logic       e2;
  } row_t;

  // set, hit, hit way, miss, valid, exp LRU4, exp FIFO, exp LRU2
  localparam row_t TBL [15] = '{
    '{4'd3, 1'b0, 2'd0, 1'b0, 4'hF, 2'd0, 2'd0, 1'b0},
    '{4'd3, 1'b1, 2'd0, 1'b0, 4'hF, 2'd0, 2'd0, 1'b0},
    '{4'd3, 1'b1, 2'd2, 1'b0, 4'hF, 2'd1, 2'd0, 1'b1},
    '{4'd3, 1'b1, 2'd1, 1'b0, 4'hF, 2'd1, 2'd0, 1'b1},
    '{4'd3, 1'b0, 2'd0, 1'b0, 4'hF, 2'd3, 2'd0, 1'b0},
    '{4'd3, 1'b0, 2'd0, 1'b1, 4'hF, 2'd3, 2'd0, 1'b0},
    '{4'd3, 1'b0, 2'd0, 1'b0, 4'hF, 2'd0, 2'd1, 1'b1},
    '{4'd3, 1'b1, 2'd2, 1'b1, 4'hF, 2'd0, 2'd1, 1'b1},
    '{4'd3, 1'b0, 2'd0, 1'b0, 4'hF, 2'd2, 2'd2, 1'b0},
    '{4'd5, 1'b0, 2'd0, 1'b0, 4'hF, 2'd0, 2'd0, 1'b0},
    '{4'd3, 1'b0, 2'd0, 1'b0, 4'h7, 2'd3, 2'd3, 1'b0},
    '{4'd3, 1'b0, 2'd0, 1'b1, 4'h7, 2'd3, 2'd3, 1'b0},
    '{4'd3, 1'b0, 2'd0, 1'b0, 4'hF, 2'd2, 2'd3, 1'b1},
    '{4'd3, 1'b1, 2'd2, 1'b0, 4'hF, 2'd2, 2'd3, 1'b1},
    '{4'd3, 1'b0, 2'd0, 1'b0, 4'hF, 2'd1, 2'd3, 1'b1}
  };

  task automatic chk(input string tag, input string what, input logic [3:0] act,
                     input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_rand(input logic [3:0] v);
    if (v == 4'hF) return 2'(cyc % 4);
    for (int i = 0; i < 4; i++) if (!v[i]) return 2'(i);
    return 2'd0;
  endfunction

  task automatic drive(input logic [3:0] s, input logic h, input logic [1:0] hw,
                       input logic m, input logic [3:0] v);
    @(negedge clk);
    set_idx = s; hit_vld = h; hit_way = hw; miss_vld = m; way_valid = v;
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; set_idx = '0; hit_vld = 1'b0; hit_way = '0; miss_vld = 1'b0;
    way_valid = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state on two sets
    chk("R1", "lru4 set0", {2'b0, v_lru4}, 4'd0);
    chk("R1", "fifo set0", {2'b0, v_fifo}, 4'd0);
    chk("R1", "rand",      {2'b0, v_rand}, 4'd0);
    chk("R1", "lru2 set0", {3'b0, v_lru2}, 4'd0);
    set_idx = 4'd9; #1;
    chk("R1", "lru4 set9", {2'b0, v_lru4}, 4'd0);
    chk("R1", "fifo set9", {2'b0, v_fifo}, 4'd0);

    // table walk: R9 lru4, R5 fifo, R4 random, R10 two-way, R3 single way
    for (int r = 0; r < 15; r++) begin
      drive(TBL[r].s, TBL[r].h, TBL[r].hw, TBL[r].m, TBL[r].v);
      chk("R9",  $sformatf("row %0d lru4", r), {2'b0, v_lru4}, {2'b0, TBL[r].e4});
      chk("R5",  $sformatf("row %0d fifo", r), {2'b0, v_fifo}, {2'b0, TBL[r].ef});
      chk("R4",  $sformatf("row %0d rand", r), {2'b0, v_rand}, {2'b0, exp_rand(TBL[r].v)});
      chk("R10", $sformatf("row %0d lru2", r), {3'b0, v_lru2}, {3'b0, TBL[r].e2});
      chk("R3",  $sformatf("row %0d dm",   r), {3'b0, v_dm},   4'd0);
    end

    // R2: empty way 1 wins over every policy
    drive(4'd3, 1'b0, 2'd0, 1'b0, 4'b1101);
    chk("R2", "lru4 empty", {2'b0, v_lru4}, 4'd1);
    chk("R2", "fifo empty", {2'b0, v_fifo}, 4'd1);
    chk("R2", "rand empty", {2'b0, v_rand}, 4'd1);
    chk("R2", "lru2 empty", {3'b0, v_lru2}, 4'd1);
    // R12: same-cycle response to way_valid, no edge in between
    way_valid = 4'b1110; #1;
    chk("R12", "lru4 way0 empty", {2'b0, v_lru4}, 4'd0);
    way_valid = 4'hF; #1;
    chk("R12", "lru4 full again", {2'b0, v_lru4}, 4'd1);

    // R7: hit on way 1 makes it most recent
    drive(4'd3, 1'b1, 2'd1, 1'b0, 4'hF);
    chk("R12", "lru4 before hit update", {2'b0, v_lru4}, 4'd1);
    drive(4'd3, 1'b0, 2'd0, 1'b0, 4'hF);
    chk("R7", "lru4 after hit", {2'b0, v_lru4}, 4'd0);
    chk("R7", "lru2 after hit", {3'b0, v_lru2}, 4'd0);
    // R6: fifo pointer untouched by hits
    chk("R6", "fifo after hits", {2'b0, v_fifo}, 4'd3);

    // R8: miss fill becomes most recent; fifo wraps 3 -> 0
    drive(4'd3, 1'b0, 2'd0, 1'b1, 4'hF);
    chk("R8", "fifo at miss", {2'b0, v_fifo}, 4'd3);
    drive(4'd3, 1'b0, 2'd0, 1'b0, 4'hF);
    chk("R8", "lru4 after fill", {2'b0, v_lru4}, 4'd3);
    chk("R8", "lru2 after fill", {3'b0, v_lru2}, 4'd1);
    chk("R5", "fifo wrap",       {2'b0, v_fifo}, 4'd0);

    // R5: per-set pointers
    drive(4'd7, 1'b0, 2'd0, 1'b1, 4'hF);
    chk("R5", "fifo set7 first",  {2'b0, v_fifo}, 4'd0);
    drive(4'd7, 1'b0, 2'd0, 1'b1, 4'hF);
    chk("R5", "fifo set7 second", {2'b0, v_fifo}, 4'd1);
    drive(4'd7, 1'b0, 2'd0, 1'b0, 4'hF);
    chk("R5", "fifo set7 after",  {2'b0, v_fifo}, 4'd2);
    set_idx = 4'd3; #1;
    chk("R5", "fifo set3 kept",   {2'b0, v_fifo}, 4'd0);

    // R11: miss outranks hit in the same cycle
    drive(4'd12, 1'b1, 2'd1, 1'b1, 4'hF);
    chk("R11", "lru4 victim", {2'b0, v_lru4}, 4'd0);
    drive(4'd12, 1'b0, 2'd0, 1'b0, 4'hF);
    chk("R11", "lru4 after", {2'b0, v_lru4}, 4'd1);
    chk("R11", "lru2 after", {3'b0, v_lru2}, 4'd1);

    // R1: reset in mid-run restores the start state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rst_n = 1'b1;
    set_idx = 4'd3; hit_vld = 1'b0; miss_vld = 1'b0; way_valid = 4'hF;
    #1;
    chk("R1", "lru4 set3 after reset", {2'b0, v_lru4}, 4'd0);
    chk("R1", "lru2 set3 after reset", {3'b0, v_lru2}, 4'd0);
    chk("R1", "rand after reset",      {2'b0, v_rand}, 4'd0);
    set_idx = 4'd7; #1;
    chk("R1", "fifo set7 after reset", {2'b0, v_fifo}, 4'd0);

    finish_run();
  end

endmodule